// File: doc/BRIEF.md
# Three-Channel Phase-Offset Numerically Controlled Oscillator

This block is a numerically controlled oscillator with one shared phase accumulator and three clock outputs. The host gives an output frequency in hertz and a phase offset in whole degrees for each output. A one-cycle load strobe captures these values. The block then turns them into a binary tuning increment and three binary phase words, using one bit-serial divider that it reuses for every value. The accumulator adds the tuning increment on every reference clock cycle. Each output adds its own phase word to the accumulator value, and the top bit of that sum is the output's square-wave clock.

Channel 0 drives the single-ended output. Channels 1 and 2 drive the two differential-class outputs. The new frequency and all three offsets are applied in one step once the conversion is done, so an output never shows a mix of old and new settings. A frequency above the 200 MHz nominal upper limit is converted like any other value and is not rejected.

Top module: `tri_phase_nco`

## Requirements
- R1: After reset, `phase` is 0, `busy` is 0, `ch_clk` is 0, and `phase` stays 0 until the first load completes, because the tuning increment resets to 0.
- R2: A `load` sampled while `busy` is 0 sets `busy` on the next cycle. `busy` then stays high for exactly 4 × (FREQ_W + ACC_W) cycles, which is 304 with the default parameters.
- R3: Once a frequency `f` is applied, `phase` grows on every clock by round(f × 2^48 / REF_HZ) modulo 2^48, with REF_HZ at 500 000 000 by default. This gives 1 Hz programming resolution.
- R4: A frequency above 200 MHz, such as 250 MHz, is converted with the same formula as in R3 and is applied.
- R5: An offset of `d` degrees becomes the word round(d × 2^48 / 360). Channel k reads its offset from `deg_in[9k+8:9k]`, and `ch_clk[k]` is the top bit of (`phase` + that word) modulo 2^48.
- R6: An offset of 360 degrees gives the same channel output as an offset of 0 degrees.
- R7: Loading a new offset for one channel, with the frequency and the other offsets unchanged, leaves the `phase` increment and the other channels' outputs unchanged.
- R8: The new tuning increment and offsets are applied at the clock edge where `busy` falls. The step of `phase` at that edge still uses the old increment, and the next step uses the new one.
- R9: A `load` asserted while `busy` is 1 is ignored, and the values captured earlier are the ones applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that drives the accumulator |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that captures `freq_hz` and `deg_in` when idle |
| freq_hz | input | FREQ_W (28) | Requested output frequency in hertz |
| deg_in | input | NCH*DEG_W (27) | Per-channel phase offsets in degrees, 9 bits each, channel 0 in the low bits |
| busy | output | 1 | High while a conversion is running |
| phase | output | ACC_W (48) | Shared phase accumulator value |
| ch_clk | output | NCH (3) | Square-wave clock of each channel |

## Verification
The reference model is run with several frequencies:
- 10 MHz, where the clock period is an exact number of reference cycles;
- 200 MHz and 37 MHz, where rounding matters;
- 250 MHz, to show that out-of-range requests are accepted.

Comparing every cycle against these frequencies separates a wrong tuning rounding from a wrong offset rounding. Offset sets of 0/90/180 and 45/0/270 degrees cover the channel slicing. A 0/360 pair checks that 360 wraps to 0. A load that changes only channel 2 shows whether an offset update disturbs the shared accumulator or the other channels. A second load issued during a conversion, with a very different frequency, shows whether a busy conversion can be corrupted. The step of `phase` on each side of the `busy` fall separates an atomic update from an update that lands a cycle early or late.

// File: rtl/tri_phase_nco.sv
module tri_phase_nco #(
  parameter int unsigned REF_HZ = 500_000_000,
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned FREQ_W = 28,
  parameter int unsigned DEG_W  = 9,
  parameter int unsigned NCH    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [FREQ_W-1:0]      freq_hz,
  input  logic [NCH*DEG_W-1:0]   deg_in,
  output logic                   busy,
  output logic [ACC_W-1:0]       phase,
  output logic [NCH-1:0]         ch_clk
);
  localparam int unsigned XW    = (FREQ_W > DEG_W) ? FREQ_W : DEG_W;
  localparam int unsigned STEPS = XW + ACC_W;
  localparam int unsigned LAT   = (NCH + 1) * STEPS;
  localparam int unsigned RW    = $clog2(REF_HZ + 1);
  localparam int unsigned CW    = $clog2(STEPS);
  localparam int unsigned PW    = $clog2(NCH + 1);
  localparam int unsigned TURN  = 360;
  localparam logic [RW-1:0]    REF_DIV  = RW'(REF_HZ);
  localparam logic [RW-1:0]    TURN_DIV = RW'(TURN);
  localparam logic [ACC_W-1:0] REF_HALF  = ACC_W'(REF_HZ / 2);
  localparam logic [ACC_W-1:0] TURN_HALF = ACC_W'(TURN / 2);

  logic [PW-1:0]        pass_q;
  logic [CW-1:0]        cnt_q;
  logic [RW-1:0]        rem_q;
  logic [STEPS-1:0]     dvd_q;
  logic [ACC_W-1:0]     quo_q;
  logic [NCH*DEG_W-1:0] deg_q;
  logic [ACC_W-1:0]     res_q [NCH];
  logic [ACC_W-1:0]     tune_q;
  logic [ACC_W-1:0]     off_q [NCH];

  logic [RW-1:0]    divisor;
  logic [RW:0]      trial;
  logic             take;
  logic [RW-1:0]    rem_nx;
  logic [ACC_W-1:0] quo_nx;
  logic [DEG_W-1:0] next_deg;

  assign divisor  = (pass_q == '0) ? REF_DIV : TURN_DIV;
  assign trial    = {rem_q, dvd_q[STEPS-1]};
  assign take     = trial >= {1'b0, divisor};
  assign rem_nx   = take ? RW'(trial - {1'b0, divisor}) : trial[RW-1:0];
  assign quo_nx   = {quo_q[ACC_W-2:0], take};
  assign next_deg = deg_q[pass_q*DEG_W +: DEG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pass_q <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      deg_q  <= '0;
      tune_q <= '0;
      phase  <= '0;
      for (int k = 0; k < NCH; k++) begin
        res_q[k] <= '0;
        off_q[k] <= '0;
      end
    end else begin
      phase <= phase + tune_q;
      if (!busy) begin
        if (load) begin
          busy   <= 1'b1;
          pass_q <= '0;
          cnt_q  <= '0;
          rem_q  <= '0;
          quo_q  <= '0;
          deg_q  <= deg_in;
          dvd_q  <= {XW'(freq_hz), REF_HALF};
        end
      end else begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        dvd_q <= dvd_q << 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(STEPS - 1)) begin
          cnt_q <= '0;
          rem_q <= '0;
          quo_q <= '0;
          if (pass_q == PW'(NCH)) begin
            busy   <= 1'b0;
            tune_q <= res_q[0];
            for (int k = 0; k < NCH - 1; k++) off_q[k] <= res_q[k+1];
            off_q[NCH-1] <= quo_nx;
          end else begin
            res_q[pass_q] <= quo_nx;
            pass_q        <= pass_q + 1'b1;
            dvd_q         <= {XW'(next_deg), TURN_HALF};
          end
        end
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic carry;
    assign carry     = phase[ACC_W-2:0] > ~off_q[k][ACC_W-2:0];
    assign ch_clk[k] = phase[ACC_W-1] ^ off_q[k][ACC_W-1] ^ carry;
  end
endmodule

// File: rtl/tri_phase_nco_chk.sv
module tri_phase_nco_chk #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned LAT   = 304
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             busy,
  input logic [ACC_W-1:0] phase
);
  int unsigned bcnt;
  logic [1:0]  vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= 0;
      vld  <= '0;
    end else begin
      bcnt <= busy ? bcnt + 1 : 0;
      if (vld != 2'd3) vld <= vld + 1'b1;
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load && !busy |=> busy); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bcnt < LAT - 1 |=> busy); // R9
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bcnt == LAT - 1 |=> !busy); // R8
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !load |=> !busy); // R2
  AST_STEADY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    vld == 2'd3 && $past(!busy) && $past(!busy, 2) |->
      (phase - $past(phase)) == ($past(phase) - $past(phase, 2))); // R3
endmodule

bind tri_phase_nco tri_phase_nco_chk #(.ACC_W(ACC_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .phase(phase)
);

// File: tb/tb_tri_phase_nco.sv
`timescale 1ns/1ps
module tb_tri_phase_nco;
  localparam int unsigned REF = 500_000_000;
  localparam int LAT = 4 * (28 + 48);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [27:0] freq_hz = '0;
  logic [26:0] deg_in = '0;
  logic        busy;
  logic [47:0] phase;
  logic [2:0]  ch_clk;

  tri_phase_nco #(.REF_HZ(REF)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .freq_hz(freq_hz),
    .deg_in(deg_in), .busy(busy), .phase(phase), .ch_clk(ch_clk)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;

  function automatic logic [47:0] tune_of(input longint unsigned f);
    logic [127:0] n;
    n = (128'(f) << 48) + 128'(REF / 2);
    return 48'(n / 128'(REF));
  endfunction

  function automatic logic [47:0] off_of(input int unsigned d);
    logic [127:0] n;
    n = (128'(d) << 48) + 128'd180;
    return 48'(n / 128'd360);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [47:0] m_phase, m_tune;
  logic [47:0] m_off [3];
  int          m_cnt;
  longint unsigned m_f;
  int unsigned m_d [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = '0; m_tune = '0; m_cnt = 0; m_f = 0;
      for (int k = 0; k < 3; k++) begin m_off[k] = '0; m_d[k] = 0; end
    end else begin
      m_phase = m_phase + m_tune;
      if (m_cnt == 0) begin
        if (load) begin
          m_cnt = LAT;
          m_f = longint'(freq_hz);
          for (int k = 0; k < 3; k++) m_d[k] = int'(deg_in[k*9 +: 9]);
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_tune = tune_of(m_f);
          for (int k = 0; k < 3; k++) m_off[k] = off_of(m_d[k]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [47:0] s;
      chk(phase == m_phase, "R3", "phase", 64'(phase), 64'(m_phase));
      chk(busy == (m_cnt != 0), "R2", "busy", 64'(busy), 64'(m_cnt != 0));
      for (int k = 0; k < 3; k++) begin
        s = m_phase + m_off[k];
        chk(ch_clk[k] == s[47], "R5", $sformatf("ch_clk[%0d]", k),
            64'(ch_clk[k]), 64'(s[47]));
      end
    end
  end

  logic [47:0] cur_tune = '0;

  task automatic do_load(input int unsigned f, input int unsigned d0, input int unsigned d1,
                         input int unsigned d2, input int unsigned inj_f, input string tag);
    logic [47:0] p_prev, p0, p1, new_t;
    new_t = tune_of(longint'(f));
    @(negedge clk);
    freq_hz = 28'(f); deg_in = {9'(d2), 9'(d1), 9'(d0)}; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    if (inj_f != 0) begin
      repeat (10) @(negedge clk);
      freq_hz = 28'(inj_f); deg_in = {9'd7, 9'd7, 9'd7}; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
    end
    p_prev = phase;
    while (busy) begin p_prev = phase; @(negedge clk); end
    p0 = phase;
    @(negedge clk);
    p1 = phase;
    chk(p0 - p_prev == cur_tune, "R8", "step at busy fall", 64'(p0 - p_prev), 64'(cur_tune));
    chk(p1 - p0 == new_t, tag, "step after apply", 64'(p1 - p0), 64'(new_t));
    cur_tune = new_t;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] s0, s1, t_before;
    repeat (5) @(negedge clk);
    chk(phase == 0, "R1", "reset phase", 64'(phase), 0);
    chk(busy == 0, "R1", "reset busy", 64'(busy), 0);
    chk(ch_clk == 0, "R1", "reset ch_clk", 64'(ch_clk), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (4) @(negedge clk);
    chk(phase == 0, "R1", "phase idle before load", 64'(phase), 0);

    do_load(10_000_000, 0, 90, 180, 0, "R3");
    repeat (120) @(negedge clk);
    do_load(200_000_000, 45, 0, 270, 0, "R3");
    repeat (60) @(negedge clk);
    do_load(250_000_000, 10, 20, 30, 0, "R4");
    repeat (60) @(negedge clk);
    do_load(37_000_001, 0, 360, 0, 0, "R3");
    for (int i = 0; i < 200; i++) begin
      chk(ch_clk[1] == ch_clk[0], "R6", "360 vs 0", 64'(ch_clk[1]), 64'(ch_clk[0]));
      @(negedge clk);
    end

    t_before = cur_tune;
    do_load(37_000_001, 0, 360, 123, 0, "R7");
    chk(cur_tune == t_before, "R7", "increment unchanged", 64'(cur_tune), 64'(t_before));
    for (int i = 0; i < 150; i++) begin
      s0 = phase + off_of(0);
      s1 = phase + off_of(360);
      chk(ch_clk[0] == s0[47], "R7", "ch0 untouched", 64'(ch_clk[0]), 64'(s0[47]));
      chk(ch_clk[1] == s1[47], "R7", "ch1 untouched", 64'(ch_clk[1]), 64'(s1[47]));
      @(negedge clk);
    end

    do_load(20_000_000, 30, 60, 90, 150_000_000, "R9");
    repeat (100) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule